// File: doc/BRIEF.md
# Triple-Buffered Framed Serial Receiver

This block is the receive half of a framed synchronous serial port. It runs on the system clock. A bit-enable input marks each active edge of the receive bit clock. The block idles until it sees a frame-sync pulse on an enabled edge. It then waits a programmable number of bit periods and shifts in one word, most significant bit first, of a selectable length between 8 and 32 bits.

A completed word passes through three register stages: a shift stage, a holding buffer and a CPU-facing data register pair. Adjacent stages use a full/empty handshake. Each stage has a low 16-bit half. Words longer than 16 bits also use a high half, which holds the upper bits. While a word moves from the buffer into the data registers, it is converted. Either an 8-bit companded sample is expanded to a left-justified 16-bit linear value, or the word is justified and filled as the justification control selects.

Software sees two data outputs, a ready flag and a sticky overrun flag. It acknowledges a word with single-cycle read strobes on the high and low halves. Acknowledging the low half empties the data stage, and the buffered word, if there is one, moves in on the next clock.

Top module: `srx_receiver`

## Requirements
- R1: After reset, `rxReady` and `overrun` are 0 and both data outputs read 0.
- R2: A word starts only on a cycle with `rxBitEn` and `frameSync` both high. Enabled bit edges without frame sync while idle shift nothing and never set `rxReady`.
- R3: `delaySel` gives the data delay:
  - 0: the bit sampled on the frame-sync edge is the first data bit.
  - 1: the first data bit is taken on the next enabled edge.
  - 2 or 3: the first data bit is taken two enabled edges after frame sync.
  - Bits arrive MSB first.
- R4: `wordSel` encodes the word length: 0=8, 1=12, 2=16, 3=20, 4=24, 5/6/7=32 bits. For lengths of 16 bits or less, `rdDataHi` is 0. For longer words, `rdDataHi` carries the upper bits of the 32-bit result.
- R5: A completed word enters the buffer if the buffer is empty or is emptying in the same cycle. Otherwise the word is dropped, the buffer keeps its older word, and `overrun` is set and stays set until reset.
- R6: A buffered word moves into the data registers only while `rxReady` is 0. When it lands, `rxReady` goes to 1, and the data outputs stay stable until that word is acknowledged.
- R7: A low-half read strobe (`readLo`) accepted while `rxReady` is 1 clears `rxReady`. A waiting buffered word is copied in on the following cycle.
- R8: For a word longer than 16 bits, `readLo` is ignored until `readHi` has been strobed since that word landed. `rxReady` and the data then stay unchanged.
- R9: `compSel` 2'b10 selects mu-law expansion and 2'b11 selects A-law expansion of the low 8 buffered bits. The result is the standard 16-bit signed linear value: mu-law 0x00 gives 0x8284, 0x80 gives 0x7D7C and 0xFF gives 0x0000; A-law 0xD5 gives 0x0008 and 0x55 gives 0xFFF8. `rdDataHi` is 0, and the word counts as 16 bits or less for R8.
- R10: With `compSel[1]` 0, `justSel` shapes the word at its length L:
  - 00 or 11: right-justify with zero fill.
  - 01: right-justify with sign extension from bit L-1.
  - 10: left-justify with zeros below.
  - The field is 16 bits wide when L is 16 or less and 32 bits wide otherwise.
- R11: Frame-sync pulses that arrive while a word is being delayed or shifted are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxBitEn | input | 1 | Marks an active receive bit edge |
| frameSync | input | 1 | Receive frame-sync pulse, sampled with `rxBitEn` |
| dataIn | input | 1 | Serial data, sampled with `rxBitEn` |
| wordSel | input | 3 | Word length code (R4) |
| delaySel | input | 2 | Data delay in bit periods (R3) |
| justSel | input | 2 | Justification and fill mode (R10) |
| compSel | input | 2 | Companding mode (R9) |
| readHi | input | 1 | High-half read strobe |
| readLo | input | 1 | Low-half read strobe, acknowledges the word |
| rdDataHi | output | 16 | High half of the data register |
| rdDataLo | output | 16 | Low half of the data register |
| rxReady | output | 1 | Data register holds an unacknowledged word |
| overrun | output | 1 | Sticky: a completed word found the buffer full |

## Verification
The checker watches the stage handshake on every cycle:
- `rxReady` rises only when the buffer was full.
- `rxReady` falls only right after a low read.
- The data outputs hold steady while a word waits.
- A word completing into a full buffer behind a full data stage raises `overrun`, and `overrun` never clears.

The data path can only be shown by the bench's scenarios. These cover the delay alignment, the word lengths, the justification and companding arithmetic, the read-order enforcement for wide words, and the drop of the third word in an overrun.

// File: rtl/srx_pkg.sv
package srx_pkg;

  localparam int HALF_W = 16;
  localparam int FULL_W = 2 * HALF_W;
  localparam int CNT_W  = $clog2(FULL_W + 1);
  localparam int COMP_W = 8;

  // Strobes from control to datapath
  typedef struct packed {
    logic shiftEn;
    logic loadBuf;
    logic loadDrr;
  } srxStrobes_t;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_SKIP  = 2'd1,
    RX_SHIFT = 2'd2
  } rxState_e;

  // Word length in bits for a length code
  function automatic logic [CNT_W-1:0] wordBits(input logic [2:0] sel);
    case (sel)
      3'd0:    wordBits = CNT_W'(8);
      3'd1:    wordBits = CNT_W'(12);
      3'd2:    wordBits = CNT_W'(16);
      3'd3:    wordBits = CNT_W'(20);
      3'd4:    wordBits = CNT_W'(24);
      default: wordBits = CNT_W'(32);
    endcase
  endfunction

endpackage

// File: rtl/srx_expand.sv
module srx_expand
  import srx_pkg::*;
#(
  parameter int OutW = HALF_W
) (
  input  logic [COMP_W-1:0] code,
  input  logic              aLaw,
  output logic [OutW-1:0]   linear
);

  logic [COMP_W-1:0] muX, aX;
  logic [OutW-1:0]   muBase, muMag, aBase, aMag;
  logic [2:0]        muExp, aExp;

  always_comb begin
    // mu-law: inverted code, biased segment expansion
    muX    = ~code;
    muExp  = muX[6:4];
    muBase = OutW'({muX[3:0], 3'b000}) + OutW'(16'h0084);
    muMag  = muBase << muExp;

    // A-law: even-bit inverted code, segment 0 is linear
    aX    = code ^ 8'h55;
    aExp  = aX[6:4];
    aBase = OutW'({aX[3:0], 4'b0000});
    if (aExp == 3'd0) aMag = aBase + OutW'(8);
    else              aMag = (aBase + OutW'(16'h0108)) << (aExp - 3'd1);

    if (aLaw) linear = aX[7] ? aMag : (OutW'(0) - aMag);
    else      linear = muX[7] ? (OutW'(16'h0084) - muMag) : (muMag - OutW'(16'h0084));
  end

endmodule

// File: rtl/srx_ctrl.sv
module srx_ctrl
  import srx_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        rxBitEn,
  input  logic        frameSync,
  input  logic [2:0]  wordSel,
  input  logic [1:0]  delaySel,
  input  logic        compActive,
  input  logic        readHi,
  input  logic        readLo,
  output srxStrobes_t strobes,
  output logic        rxReady,
  output logic        overrun,
  output logic        bufFull,
  output logic        wordDone
);

  rxState_e         state;
  logic [CNT_W-1:0] bitCnt;
  logic [CNT_W-1:0] len;
  logic             drrFull, drrWide, hiSeen;
  logic             takeBit, lastBit, moveOut, bufFree, loadBuf, loadLo;

  always_comb begin
    len     = wordBits(wordSel);
    takeBit = 1'b0;
    if (rxBitEn) begin
      case (state)
        RX_IDLE:  takeBit = frameSync && (delaySel == 2'd0);
        RX_SHIFT: takeBit = 1'b1;
        default:  takeBit = 1'b0;
      endcase
    end
    lastBit = takeBit && (bitCnt == len - CNT_W'(1));
    moveOut = bufFull && !drrFull;
    bufFree = !bufFull || moveOut;
    loadBuf = wordDone && bufFree;
    loadLo  = readLo && drrFull && (!drrWide || hiSeen);
    strobes.shiftEn = takeBit;
    strobes.loadBuf = loadBuf;
    strobes.loadDrr = moveOut;
  end

  // Frame and bit sequencing
  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= RX_IDLE;
      bitCnt   <= '0;
      wordDone <= 1'b0;
    end else begin
      wordDone <= lastBit;
      if (takeBit) bitCnt <= bitCnt + CNT_W'(1);
      if (lastBit) begin
        state  <= RX_IDLE;
        bitCnt <= '0;
      end else if (rxBitEn) begin
        case (state)
          RX_IDLE: if (frameSync) state <= (delaySel >= 2'd2) ? RX_SKIP : RX_SHIFT;
          RX_SKIP: state <= RX_SHIFT;
          default: state <= state;
        endcase
      end
    end
  end

  // Stage occupancy
  always_ff @(posedge clk) begin
    if (!rstN) begin
      bufFull <= 1'b0;
      drrFull <= 1'b0;
      drrWide <= 1'b0;
      hiSeen  <= 1'b0;
      overrun <= 1'b0;
    end else begin
      if (loadBuf)      bufFull <= 1'b1;
      else if (moveOut) bufFull <= 1'b0;

      if (wordDone && !bufFree) overrun <= 1'b1;

      if (moveOut) begin
        drrFull <= 1'b1;
        drrWide <= (len > CNT_W'(HALF_W)) && !compActive;
        hiSeen  <= 1'b0;
      end else begin
        if (loadLo) drrFull <= 1'b0;
        if (readHi && drrFull) hiSeen <= 1'b1;
      end
    end
  end

  assign rxReady = drrFull;

endmodule

// File: rtl/srx_dpath.sv
module srx_dpath
  import srx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  srxStrobes_t       strobes,
  input  logic              dataIn,
  input  logic [2:0]        wordSel,
  input  logic [1:0]        justSel,
  input  logic [1:0]        compSel,
  output logic [HALF_W-1:0] dataHi,
  output logic [HALF_W-1:0] dataLo
);

  logic [FULL_W-1:0] shiftReg, bufReg;
  logic [FULL_W-1:0] mask, masked, shaped;
  logic [CNT_W-1:0]  len, shAmt;
  logic [HALF_W-1:0] expanded;
  logic              narrow, signBit;

  srx_expand #(.OutW(HALF_W)) u_expand (
    .code   (bufReg[COMP_W-1:0]),
    .aLaw   (compSel[0]),
    .linear (expanded)
  );

  always_comb begin
    len    = wordBits(wordSel);
    narrow = (len <= CNT_W'(HALF_W));
    for (int i = 0; i < FULL_W; i++) mask[i] = (i < int'(len));
    masked  = bufReg & mask;
    signBit = |(masked & (FULL_W'(1) << (len - CNT_W'(1))));
    shAmt   = narrow ? (CNT_W'(HALF_W) - len) : (CNT_W'(FULL_W) - len);
    case (justSel)
      2'b01: for (int i = 0; i < FULL_W; i++) shaped[i] = (i < int'(len)) ? masked[i] : signBit;
      2'b10: shaped = masked << shAmt;
      default: shaped = masked;
    endcase
    if (narrow) shaped[FULL_W-1:HALF_W] = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      bufReg   <= '0;
      dataHi   <= '0;
      dataLo   <= '0;
    end else begin
      if (strobes.shiftEn) shiftReg <= {shiftReg[FULL_W-2:0], dataIn};
      if (strobes.loadBuf) bufReg <= shiftReg;
      if (strobes.loadDrr) begin
        if (compSel[1]) begin
          dataHi <= '0;
          dataLo <= expanded;
        end else begin
          dataHi <= shaped[FULL_W-1:HALF_W];
          dataLo <= shaped[HALF_W-1:0];
        end
      end
    end
  end

endmodule

// File: rtl/srx_receiver.sv
module srx_receiver
  import srx_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        rxBitEn,
  input  logic        frameSync,
  input  logic        dataIn,
  input  logic [2:0]  wordSel,
  input  logic [1:0]  delaySel,
  input  logic [1:0]  justSel,
  input  logic [1:0]  compSel,
  input  logic        readHi,
  input  logic        readLo,
  output logic [15:0] rdDataHi,
  output logic [15:0] rdDataLo,
  output logic        rxReady,
  output logic        overrun
);

  srxStrobes_t strobes;
  logic        bufFull;
  logic        wordDone;

  srx_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .rxBitEn    (rxBitEn),
    .frameSync  (frameSync),
    .wordSel    (wordSel),
    .delaySel   (delaySel),
    .compActive (compSel[1]),
    .readHi     (readHi),
    .readLo     (readLo),
    .strobes    (strobes),
    .rxReady    (rxReady),
    .overrun    (overrun),
    .bufFull    (bufFull),
    .wordDone   (wordDone)
  );

  srx_dpath u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .dataIn  (dataIn),
    .wordSel (wordSel),
    .justSel (justSel),
    .compSel (compSel),
    .dataHi  (rdDataHi),
    .dataLo  (rdDataLo)
  );

endmodule

// File: rtl/srx_checker.sv
module srx_checker (
  input logic        clk,
  input logic        rstN,
  input logic        readLo,
  input logic        rxReady,
  input logic        overrun,
  input logic [15:0] rdDataHi,
  input logic [15:0] rdDataLo,
  input logic        bufFull,
  input logic        wordDone
);

  // R6
  ready_from_buffer_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxReady) |-> $past(bufFull));

  // R7
  ready_clear_by_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rxReady) |-> $past(readLo));

  // R6
  data_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxReady && !readLo) |=> (rxReady && $stable(rdDataLo) && $stable(rdDataHi)));

  // R5
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wordDone && bufFull && rxReady) |=> overrun);

  // R5
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    overrun |=> overrun);

endmodule

bind srx_receiver srx_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .readLo   (readLo),
  .rxReady  (rxReady),
  .overrun  (overrun),
  .rdDataHi (rdDataHi),
  .rdDataLo (rdDataLo),
  .bufFull  (bufFull),
  .wordDone (wordDone)
);

// File: tb/srx_receiver_bench.sv
module srx_receiver_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rxBitEn = 1'b0, frameSync = 1'b0, dataIn = 1'b0;
  logic [2:0]  wordSel = 3'd0;
  logic [1:0]  delaySel = 2'd0, justSel = 2'd0, compSel = 2'd0;
  logic        readHi = 1'b0, readLo = 1'b0;
  logic [15:0] rdDataHi, rdDataLo;
  logic        rxReady, overrun;

  int  checks = 0;
  int  failures = 0;
  bit  done = 1'b0;

  always #4 clk = ~clk;

  srx_receiver u_srx_receiver (
    .clk(clk), .rstN(rstN), .rxBitEn(rxBitEn), .frameSync(frameSync), .dataIn(dataIn),
    .wordSel(wordSel), .delaySel(delaySel), .justSel(justSel), .compSel(compSel),
    .readHi(readHi), .readLo(readLo), .rdDataHi(rdDataHi), .rdDataLo(rdDataLo),
    .rxReady(rxReady), .overrun(overrun)
  );

  typedef struct packed {
    logic [2:0]  ws;
    logic [1:0]  dl;
    logic [1:0]  js;
    logic [1:0]  cs;
    logic [31:0] val;
    logic [15:0] eh;
    logic [15:0] el;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 2'd1, 2'd0, 2'd0, 32'h000000A5, 16'h0000, 16'h00A5},
    '{3'd0, 2'd0, 2'd1, 2'd0, 32'h000000A5, 16'h0000, 16'hFFA5},
    '{3'd0, 2'd2, 2'd2, 2'd0, 32'h000000A5, 16'h0000, 16'hA500},
    '{3'd1, 2'd1, 2'd1, 2'd0, 32'h000007FF, 16'h0000, 16'h07FF},
    '{3'd1, 2'd1, 2'd1, 2'd0, 32'h00000800, 16'h0000, 16'hF800},
    '{3'd2, 2'd2, 2'd0, 2'd0, 32'h0000BEEF, 16'h0000, 16'hBEEF},
    '{3'd3, 2'd1, 2'd0, 2'd0, 32'h000ABCDE, 16'h000A, 16'hBCDE},
    '{3'd3, 2'd0, 2'd1, 2'd0, 32'h00081234, 16'hFFF8, 16'h1234},
    '{3'd4, 2'd1, 2'd2, 2'd0, 32'h00123456, 16'h1234, 16'h5600},
    '{3'd5, 2'd2, 2'd0, 2'd0, 32'hDEADBEEF, 16'hDEAD, 16'hBEEF},
    '{3'd0, 2'd1, 2'd0, 2'd2, 32'h00000000, 16'h0000, 16'h8284},
    '{3'd0, 2'd1, 2'd0, 2'd2, 32'h000000FF, 16'h0000, 16'h0000},
    '{3'd0, 2'd1, 2'd0, 2'd2, 32'h00000080, 16'h0000, 16'h7D7C},
    '{3'd0, 2'd1, 2'd0, 2'd3, 32'h000000D5, 16'h0000, 16'h0008},
    '{3'd0, 2'd1, 2'd0, 2'd3, 32'h00000055, 16'h0000, 16'hFFF8},
    '{3'd1, 2'd1, 2'd3, 2'd0, 32'h00000ABC, 16'h0000, 16'h0ABC},
    '{3'd3, 2'd1, 2'd2, 2'd0, 32'h000ABCDE, 16'hABCD, 16'hE000}
  };

  function automatic int lenOf(input logic [2:0] ws);
    case (ws)
      3'd0: return 8;
      3'd1: return 12;
      3'd2: return 16;
      3'd3: return 20;
      3'd4: return 24;
      default: return 32;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input logic fs, input logic d);
    @(negedge clk);
    rxBitEn = 1'b1; frameSync = fs; dataIn = d;
    @(negedge clk);
    rxBitEn = 1'b0; frameSync = 1'b0; dataIn = 1'b0;
    @(negedge clk);
  endtask

  // Frame sync, delay slots filled with 1s, then MSB-first bits
  task automatic sendWord(input logic [31:0] val, input int len, input int dly, input bit fsMid);
    int b;
    b = len - 1;
    if (dly == 0) begin
      tick(1'b1, val[b]);
      b--;
    end else begin
      tick(1'b1, 1'b1);
      if (dly >= 2) tick(1'b1, 1'b1);
    end
    for (; b >= 0; b--) tick(fsMid && (b == len / 2), val[b]);
    repeat (6) @(negedge clk);
  endtask

  task automatic pulse(input bit hi);
    @(negedge clk);
    if (hi) readHi = 1'b1; else readLo = 1'b1;
    @(negedge clk);
    readHi = 1'b0; readLo = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1 rxReady", 32'(rxReady), 32'd0);
    check("R1 overrun", 32'(overrun), 32'd0);
    check("R1 data", {rdDataHi, rdDataLo}, 32'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R2: enabled edges with no frame sync do nothing
    wordSel = 3'd0; delaySel = 2'd0;
    for (int i = 0; i < 12; i++) tick(1'b0, 1'b1);
    repeat (4) @(negedge clk);
    check("R2 no frame", 32'(rxReady), 32'd0);

    // Table: R3 delay/MSB-first, R4 length, R9 companding, R10 justification
    for (int k = 0; k < NV; k++) begin
      wordSel = VECS[k].ws; delaySel = VECS[k].dl;
      justSel = VECS[k].js; compSel = VECS[k].cs;
      sendWord(VECS[k].val, lenOf(VECS[k].ws), int'(VECS[k].dl), 1'b0);
      check("R6 ready", 32'(rxReady), 32'd1);
      check("R4 hi", 32'(rdDataHi), 32'(VECS[k].eh));
      check(VECS[k].cs[1] ? "R9 lo" : "R3 R10 lo", 32'(rdDataLo), 32'(VECS[k].el));
      pulse(1'b1);
      pulse(1'b0);
      check("R7 cleared", 32'(rxReady), 32'd0);
    end
    compSel = 2'd0; justSel = 2'd0;

    // R11: frame sync mid-word is ignored
    wordSel = 3'd2; delaySel = 2'd1;
    sendWord(32'h00001234, 16, 1, 1'b1);
    check("R11 data", 32'(rdDataLo), 32'h1234);
    pulse(1'b0);
    check("R11 cleared", 32'(rxReady), 32'd0);

    // R8: wide word needs a high read before the low read counts
    wordSel = 3'd3;
    sendWord(32'h00012345, 20, 1, 1'b0);
    pulse(1'b0);
    check("R8 ready held", 32'(rxReady), 32'd1);
    check("R8 data held", {rdDataHi, rdDataLo}, 32'h00012345);
    pulse(1'b1);
    pulse(1'b0);
    check("R8 released", 32'(rxReady), 32'd0);

    // R5/R6/R7: fill all stages, then overrun
    wordSel = 3'd2;
    sendWord(32'h00001111, 16, 1, 1'b0);
    sendWord(32'h00002222, 16, 1, 1'b0);
    check("R6 first held", 32'(rdDataLo), 32'h1111);
    check("R5 no overrun yet", 32'(overrun), 32'd0);
    sendWord(32'h00003333, 16, 1, 1'b0);
    check("R5 overrun", 32'(overrun), 32'd1);
    check("R6 still first", 32'(rdDataLo), 32'h1111);
    pulse(1'b0);
    check("R7 next copy ready", 32'(rxReady), 32'd1);
    check("R5 buffer kept older", 32'(rdDataLo), 32'h2222);
    pulse(1'b0);
    check("R5 third dropped", 32'(rxReady), 32'd0);
    check("R5 sticky", 32'(overrun), 32'd1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule